// File: doc/BRIEF.md
# External Bus Wait-State Generator

This block stretches external memory cycles so that slow devices on an external memory port can be used. It holds one configuration word in the data address space. That word has two independent wait-count fields: one for program-memory fetches that go off chip and one for data-memory accesses that go off chip. When the core starts an external access, the block picks the field for that access class and holds a stall line high for that many clock cycles. It then signals completion.

The core presents its program request and its data request separately. It keeps each request asserted until the matching done strobe appears. Internal accesses, and reads or writes of the configuration word itself, complete in the cycle they are presented. An external access latches its wait count when it starts. A later write to the configuration word therefore affects only the accesses that follow. When both classes want the external port in the same cycle, the program fetch goes first.

Top module: `ext_wait_gen`

## Requirements
- R1: After reset the configuration word reads 16'h03FF, so both wait counts are 31. An external access started right after reset completes on its 32nd cycle.
- R2: A data write to address 16'hFFDE updates the configuration word, and a data read of that address returns it. Bits [4:0] hold the data-memory wait count and bits [9:5] hold the program-memory wait count. A data write to any other address leaves the word unchanged.
- R3: Bits [15:10] of the configuration word always read as zero, and values written to them are dropped.
- R4: An external program access under a program wait count N keeps `stall` high for exactly N cycles, counting from the cycle in which the access is first presented. `prg_done` rises in cycle N+1.
- R5: An external data access (dat_ext high, address not 16'hFFDE) uses the data wait count N. It stalls for N cycles and raises `dat_done` in cycle N+1.
- R6: With a wait count of zero, an external access completes in its first cycle and `stall` stays low.
- R7: A configuration write made while an external access is counting does not change that access's length. The next access uses the new count.
- R8: Internal accesses (prg_ext or dat_ext low) and accesses to the configuration word raise their done strobe in the same cycle and never cause `stall` on their own.
- R9: When external program and data accesses are presented together, the program access is served first. The data access begins its countdown in the cycle after `prg_done`. `stall` stays high until `dat_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prg_req | input | 1 | Program fetch presented this cycle, held until prg_done |
| prg_ext | input | 1 | The program fetch targets external memory |
| dat_req | input | 1 | Data access presented this cycle, held until dat_done |
| dat_ext | input | 1 | The data access targets external memory |
| dat_we | input | 1 | Data access is a write |
| dat_addr | input | 16 | Data word address |
| dat_wdata | input | 16 | Data write value |
| dat_rdata | output | 16 | Configuration word during a read of 16'hFFDE, otherwise zero |
| prg_done | output | 1 | Program access completes this cycle |
| dat_done | output | 1 | Data access completes this cycle |
| stall | output | 1 | Core must hold its current access |

## Verification
On every cycle, the in-line assertions check the countdown step, the return to idle after the final count, the owner staying fixed during a countdown, program-first selection, the reserved bits staying zero, the configuration word holding when not written, and the absence of stall without an external request. Only the bench's scenarios can show the end-to-end cycle counts. These are the sweep of every wait value 0 to 31 for each class, the order and spacing of two simultaneous accesses, the reset default length, and a rewrite of the configuration word part-way through an access that leaves that access's length unchanged.

// File: rtl/ewg_pkg.sv
// Package: shared constants and types for the external wait-state generator.
// Assumes a 16-bit data word and two 5-bit wait fields packed from bit 0 upward.
package ewg_pkg;
    localparam int unsigned WAIT_W = 5;
    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] CFG_ADDR = 16'hFFDE;

    // Access class owning the external port.
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PRG  = 2'd1,
        CLS_DAT  = 2'd2
    } acc_cls_e;
endpackage

// File: rtl/ewg_cfg_reg.sv
// Module: configuration word holding the two wait-count fields.
// Data count sits in the low field and program count in the next field up.
// All higher bits are reserved: they are forced to zero on write and read as zero.
// Assumes the caller already decoded the address into wr_en / rd_en.
module ewg_cfg_reg #(
    parameter int unsigned WAIT_W = ewg_pkg::WAIT_W,
    parameter int unsigned WORD_W = ewg_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [WAIT_W-1:0] prg_wait,
    output logic [WAIT_W-1:0] dat_wait
);
    localparam int unsigned USED_W = 2 * WAIT_W;
    localparam logic [WORD_W-1:0] KEEP_MASK = {{(WORD_W-USED_W){1'b0}}, {USED_W{1'b1}}};
    localparam logic [WORD_W-1:0] RESET_VAL = KEEP_MASK;

    logic [WORD_W-1:0] word_q;

    // Hold the configuration word; reset presets every wait bit to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_VAL;
        end else if (wr_en) begin
            word_q <= wdata & KEEP_MASK;
        end
    end

    // Split the fields out and drive the read port only while selected.
    always_comb begin
        dat_wait = word_q[WAIT_W-1:0];
        prg_wait = word_q[USED_W-1:WAIT_W];
        rdata    = rd_en ? word_q : '0;
    end

    // R1
    reset_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> word_q == RESET_VAL);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[WORD_W-1:USED_W] == '0);

    // R2
    hold_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word_q));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> word_q[USED_W-1:0] == $past(wdata[USED_W-1:0]));
endmodule

// File: rtl/ewg_pick.sv
// Module: selects which pending external access may start, program first,
// and forwards the wait count belonging to the chosen class.
// Assumes its output is only acted on while the countdown is idle.
module ewg_pick #(
    parameter int unsigned WAIT_W = ewg_pkg::WAIT_W
) (
    input  logic                 prg_x,
    input  logic                 dat_x,
    input  logic [WAIT_W-1:0]    prg_wait,
    input  logic [WAIT_W-1:0]    dat_wait,
    output ewg_pkg::acc_cls_e    pick_cls,
    output logic [WAIT_W-1:0]    pick_wait
);
    import ewg_pkg::*;

    // Fixed priority: program fetch beats data access.
    always_comb begin
        pick_cls  = CLS_NONE;
        pick_wait = '0;
        if (prg_x) begin
            pick_cls  = CLS_PRG;
            pick_wait = prg_wait;
        end else if (dat_x) begin
            pick_cls  = CLS_DAT;
            pick_wait = dat_wait;
        end
    end
endmodule

// File: rtl/ewg_countdown.sv
// Module: wait-state sequencer. In idle it accepts a start request. A zero
// count completes in that same cycle. A count N>0 is latched as N-1 and the
// access completes once the latched count has run down to zero, which is
// cycle N+1 of the access. Assumes the requester holds its request until done.
module ewg_countdown #(
    parameter int unsigned WAIT_W = ewg_pkg::WAIT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ewg_pkg::acc_cls_e    start_cls,
    input  logic [WAIT_W-1:0]    start_wait,
    output logic                 busy,
    output ewg_pkg::acc_cls_e    done_cls
);
    import ewg_pkg::*;

    logic              busy_q;
    logic [WAIT_W-1:0] rem_q;
    acc_cls_e          own_q;

    // Latch a new countdown in idle, or step the running one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            own_q  <= CLS_NONE;
        end else if (busy_q) begin
            if (rem_q == '0) begin
                busy_q <= 1'b0;
                own_q  <= CLS_NONE;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end else if (start_cls != CLS_NONE && start_wait != '0) begin
            busy_q <= 1'b1;
            rem_q  <= start_wait - 1'b1;
            own_q  <= start_cls;
        end
    end

    // Report which class finishes this cycle, if any.
    always_comb begin
        done_cls = CLS_NONE;
        if (busy_q) begin
            if (rem_q == '0) done_cls = own_q;
        end else if (start_cls != CLS_NONE && start_wait == '0) begin
            done_cls = start_cls;
        end
    end

    assign busy = busy_q;

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rem_q != '0) |=> (busy_q && rem_q == $past(rem_q) - 1'b1));

    // R4
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rem_q == '0) |=> !busy_q);

    // R7
    owner_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rem_q != '0) |=> $stable(own_q));
endmodule

// File: rtl/ext_wait_gen.sv
// Module: top of the external bus wait-state generator. It decodes accesses to
// the configuration word and classifies each request as internal or external.
// External requests go through priority selection and the countdown. Internal
// and configuration accesses complete at once. Assumes the core holds each
// request until its done strobe, and presents a new request only afterwards.
module ext_wait_gen #(
    parameter int unsigned WAIT_W = ewg_pkg::WAIT_W,
    parameter int unsigned WORD_W = ewg_pkg::WORD_W,
    parameter logic [WORD_W-1:0] CFG_ADDR = ewg_pkg::CFG_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prg_req,
    input  logic              prg_ext,
    input  logic              dat_req,
    input  logic              dat_ext,
    input  logic              dat_we,
    input  logic [WORD_W-1:0] dat_addr,
    input  logic [WORD_W-1:0] dat_wdata,
    output logic [WORD_W-1:0] dat_rdata,
    output logic              prg_done,
    output logic              dat_done,
    output logic              stall
);
    import ewg_pkg::*;

    logic              cfg_hit, cfg_wr, cfg_rd;
    logic              prg_x, dat_x;
    logic [WAIT_W-1:0] prg_wait, dat_wait, pick_wait;
    acc_cls_e          pick_cls, done_cls;
    logic              seq_busy;

    // Decode configuration accesses and external requests.
    always_comb begin
        cfg_hit = (dat_addr == CFG_ADDR);
        cfg_wr  = dat_req && dat_we && cfg_hit;
        cfg_rd  = dat_req && !dat_we && cfg_hit;
        prg_x   = prg_req && prg_ext;
        dat_x   = dat_req && dat_ext && !cfg_hit;
    end

    ewg_cfg_reg #(.WAIT_W(WAIT_W), .WORD_W(WORD_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .rd_en    (cfg_rd),
        .wdata    (dat_wdata),
        .rdata    (dat_rdata),
        .prg_wait (prg_wait),
        .dat_wait (dat_wait)
    );

    ewg_pick #(.WAIT_W(WAIT_W)) u_pick (
        .prg_x     (prg_x),
        .dat_x     (dat_x),
        .prg_wait  (prg_wait),
        .dat_wait  (dat_wait),
        .pick_cls  (pick_cls),
        .pick_wait (pick_wait)
    );

    ewg_countdown #(.WAIT_W(WAIT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cls  (pick_cls),
        .start_wait (pick_wait),
        .busy       (seq_busy),
        .done_cls   (done_cls)
    );

    // Completion per class, and a stall while any presented access is unfinished.
    always_comb begin
        prg_done = (prg_req && !prg_ext) || (done_cls == CLS_PRG);
        dat_done = (dat_req && !dat_x)   || (done_cls == CLS_DAT);
        stall    = (prg_req && !prg_done) || (dat_req && !dat_done);
    end

    // R8
    no_ext_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prg_x && !dat_x && !seq_busy) |-> !stall);

    // R9
    prg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_x && dat_x && !seq_busy) |-> (done_cls != CLS_DAT));

    // R6
    done_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_done && !(dat_req && !dat_done)) |-> !stall);
endmodule

// File: tb/ext_wait_gen_test.sv
module ext_wait_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CFG = 16'hFFDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prg_req = 1'b0, prg_ext = 1'b0;
    logic        dat_req = 1'b0, dat_ext = 1'b0, dat_we = 1'b0;
    logic [15:0] dat_addr = '0, dat_wdata = '0;
    logic [15:0] dat_rdata;
    logic        prg_done, dat_done, stall;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_wait_gen uut (
        .clk(clk), .rst_n(rst_n),
        .prg_req(prg_req), .prg_ext(prg_ext),
        .dat_req(dat_req), .dat_ext(dat_ext), .dat_we(dat_we),
        .dat_addr(dat_addr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .prg_done(prg_done), .dat_done(dat_done), .stall(stall)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] a, input logic [15:0] v);
        @(negedge clk);
        prg_req = 0; dat_req = 1; dat_ext = 0; dat_we = 1; dat_addr = a; dat_wdata = v;
        #1;
        check("R8 write done", int'(dat_done), 1);
        check("R8 write no stall", int'(stall), 0);
        @(negedge clk);
        dat_req = 0; dat_we = 0;
    endtask

    task automatic cfg_read(output logic [15:0] v);
        @(negedge clk);
        prg_req = 0; dat_req = 1; dat_ext = 0; dat_we = 0; dat_addr = CFG;
        #1;
        v = dat_rdata;
        @(negedge clk);
        dat_req = 0;
    endtask

    // Present accesses and record done cycles and stall count; optional config write at wr_cyc.
    task automatic run(input bit p, input bit d, input int wr_cyc, input logic [15:0] wr_val,
                       output int pdc, output int ddc, output int stalls);
        bit pon = p;
        bit don = d;
        pdc = 0; ddc = 0; stalls = 0;
        for (int c = 1; c <= 80 && (pon || don); c++) begin
            @(negedge clk);
            prg_req = pon; prg_ext = 1'b1;
            if (c == wr_cyc) begin
                dat_req = 1; dat_ext = 0; dat_we = 1; dat_addr = CFG; dat_wdata = wr_val;
            end else begin
                dat_req = don; dat_ext = 1; dat_we = 0; dat_addr = 16'h0100;
            end
            #1;
            if (stall) stalls++;
            if (pon && prg_done) begin pdc = c; pon = 0; end
            if (don && dat_done) begin ddc = c; don = 0; end
        end
        @(negedge clk);
        prg_req = 0; dat_req = 0; dat_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int pdc, ddc, st;
        repeat (3) @(negedge clk);
        #1;
        check("R1 idle stall", int'(stall), 0);
        rst_n = 1;

        cfg_read(rv);
        check("R1 reset value", int'(rv), 16'h03FF);
        run(1, 0, 0, '0, pdc, ddc, st);
        check("R1 program default length", pdc, 32);
        run(0, 1, 0, '0, pdc, ddc, st);
        check("R1 data default length", ddc, 32);

        cfg_write(CFG, 16'hFFFF);
        cfg_read(rv);
        check("R3 reserved dropped", int'(rv), 16'h03FF);
        cfg_write(CFG, 16'hFC00);
        cfg_read(rv);
        check("R3 reserved only", int'(rv), 0);

        cfg_write(CFG, 16'h0123);
        cfg_read(rv);
        check("R2 readback", int'(rv), 16'h0123);
        cfg_write(16'h0200, 16'h03FF);
        cfg_read(rv);
        check("R2 other address ignored", int'(rv), 16'h0123);

        for (int n = 0; n < 32; n++) begin
            cfg_write(CFG, 16'((n << 5) | (31 - n)));
            run(1, 0, 0, '0, pdc, ddc, st);
            check("R4 program done cycle", pdc, n + 1);
            check("R4 program stall cycles", st, n);
            if (n == 0) check("R6 program zero wait", st, 0);
        end
        for (int n = 0; n < 32; n++) begin
            cfg_write(CFG, 16'(((31 - n) << 5) | n));
            run(0, 1, 0, '0, pdc, ddc, st);
            check("R5 data done cycle", ddc, n + 1);
            check("R5 data stall cycles", st, n);
            if (n == 0) check("R6 data zero wait", st, 0);
        end

        cfg_write(CFG, 16'(10 << 5));
        run(1, 0, 3, 16'(2 << 5), pdc, ddc, st);
        check("R7 running access length", pdc, 11);
        check("R7 running access stalls", st, 10);
        run(1, 0, 0, '0, pdc, ddc, st);
        check("R7 next access uses new count", pdc, 3);

        cfg_write(CFG, 16'h03FF);
        @(negedge clk);
        prg_req = 1; prg_ext = 0;
        #1;
        check("R8 internal program done", int'(prg_done), 1);
        check("R8 internal program stall", int'(stall), 0);
        @(negedge clk);
        prg_req = 0; dat_req = 1; dat_ext = 0; dat_we = 0; dat_addr = 16'h0300;
        #1;
        check("R8 internal data done", int'(dat_done), 1);
        check("R8 internal data stall", int'(stall), 0);
        @(negedge clk);
        dat_req = 0;

        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                int pv = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 5 : 31;
                int dv = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 5 : 31;
                cfg_write(CFG, 16'((pv << 5) | dv));
                run(1, 1, 0, '0, pdc, ddc, st);
                check("R9 program first", pdc, pv + 1);
                check("R9 data after program", ddc, pv + 2 + dv);
                check("R9 stall span", st, pv + 1 + dv);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule